// File: doc/BRIEF.md
# Serial Audio Port Control and Status Registers

This block is the register front end of a serial audio port. It holds one control word, which configures and starts the serial engine, and one status word, which reports the engine's busy state and latches FIFO error events. Software reaches both words over a simple single-cycle register bus. Each word has three addresses: a plain address that replaces the register, a set alias that ORs the written ones into it, and a clear alias that removes the written ones from it. With the aliases, a single bit such as run can be changed without a read-modify-write.

The serial engine and its FIFOs sit outside this block. They report through a busy level and two one-cycle error pulses, and they take their configuration from the mirrored control word. The two latched FIFO error flags, gated by an enable bit in control, drive a registered interrupt output. Holding the soft-reset bit keeps the whole port in its reset configuration and discards error flags.

Top module: `sap_csr_top`

## Requirements
- R1: Control sits at byte offset 0x00 and status at 0x10. Within each register, offset +0x0 replaces the value, +0x4 ORs the write data in and +0x8 clears the bits that are one in the write data. Writes need bus_sel and bus_wr high in the same cycle and take effect at the next clock edge. A read returns the register at any of its three aliases, combinationally in the same cycle. Offset +0xC, any address with bits [1:0] not zero and any address at or above 0x20 reads as zero, and writes there change nothing.
- R2: After reset the control word is 0xC000_0000 (soft reset bit 31 and clock gate bit 30 set), the status flags are zero and irq_o is low.
- R3: While control bit 31 is one, every other control bit holds its reset value. A write that leaves bit 31 at one yields 0xC000_0000. A write that makes bit 31 zero applies the rest of its data in the same cycle.
- R4: Control bits are: 0 run, 1 receive mode, 2 follower clocking, 3 FIFO-error interrupt enable, [5:4] word length, 6 one-bit frame delay, 7 right justify, 8 frame clock polarity, 9 bit clock edge, [12:10] master clock divider, 13 base rate select, 30 clock gate, 31 soft reset. Bits [29:14] always read zero. ctl_o always equals the control register.
- R5: While eng_busy is high, control bits 1, 2 and 4 to 13 keep their values through any write; bits 0, 3, 30 and 31 stay writable. Status bit 0 reads the current eng_busy level.
- R6: Status bit 1 (underflow) and bit 2 (overflow) set at the edge after a one-cycle pulse on eng_underflow or eng_overflow, and stay set until a one is written to that bit at the status clear alias 0x18. An event in the same cycle as the clear of its flag wins, leaving the flag set.
- R7: Writes to the status plain address 0x10 and set alias 0x14 have no effect on status.
- R8: While control bit 31 is one, both status flags are zeroed at each edge and events are ignored.
- R9: irq_o is registered: at each edge it takes control bit 3 AND (underflow OR overflow) as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| eng_busy | input | 1 | Serial engine is transferring |
| eng_underflow | input | 1 | One-cycle FIFO underflow event |
| eng_overflow | input | 1 | One-cycle FIFO overflow event |
| ctl_o | output | 32 | Control word to the serial engine |
| irq_o | output | 1 | FIFO error interrupt |

## Verification
Two functions can fall in one cycle: an engine error pulse and a software clear of the same flag at 0x18, and likewise a busy-locked configuration write together with a soft-reset or run change. The bench provokes the flag case directly with a clear of underflow in the cycle of an underflow pulse, and then at random by mixing event pulses, busy levels and writes to all aliases. The flag is judged by the status read after the edge, which must still show it set, while the lock is judged by ctl_o holding the locked fields and taking the others.

// File: rtl/sap_csr_pkg.sv
// Shared constants, types and helpers of the serial audio port registers.
// Assumes a 32-bit register word and 16-byte register slots.
package sap_csr_pkg;

    localparam int CSR_W = 32;

    // Control bit positions
    localparam int B_RUN    = 0;
    localparam int B_RXMODE = 1;
    localparam int B_FOLLOW = 2;
    localparam int B_IEN    = 3;
    localparam int B_CGATE  = 30;
    localparam int B_SRST   = 31;

    // Status bit positions
    localparam int S_BUSY     = 0;
    localparam int S_FLAG_LSB = 1;
    localparam int NUM_FLAGS  = 2;

    localparam logic [CSR_W-1:0] CTRL_RST   = 32'hC000_0000;
    localparam logic [CSR_W-1:0] CTRL_WMASK = 32'hC000_3FFF;
    localparam logic [CSR_W-1:0] LOCK_MASK  = 32'h0000_3FF6;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } wr_op_e;

    // Merge write data into an old value according to the alias used
    function automatic logic [CSR_W-1:0] apply_op(
        input logic [CSR_W-1:0] old_v,
        input logic [CSR_W-1:0] wd,
        input wr_op_e           op
    );
        case (op)
            OP_WRITE: apply_op = wd;
            OP_SET:   apply_op = old_v | wd;
            OP_CLEAR: apply_op = old_v & ~wd;
            default:  apply_op = old_v;
        endcase
    endfunction

endpackage

// File: rtl/sap_csr_decode.sv
// Address decoder: maps a byte address to a register slot and an alias.
// Assumes both register offsets are 16-byte aligned and distinct.
module sap_csr_decode
    import sap_csr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h10
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              ctrl_hit,
    output logic              stat_hit,
    output logic              ctrl_wen,
    output logic              stat_wen,
    output wr_op_e            op
);
    localparam int SLOT_LSB = 4;

    logic slot_ok;

    // Decide whether the address names a mapped alias of a slot
    always_comb begin
        op       = wr_op_e'(addr[3:2]);
        slot_ok  = sel && (addr[1:0] == 2'b00) && (op != OP_NONE);
        ctrl_hit = slot_ok && (addr[ADDR_W-1:SLOT_LSB] == CTRL_OFS[ADDR_W-1:SLOT_LSB]);
        stat_hit = slot_ok && (addr[ADDR_W-1:SLOT_LSB] == STAT_OFS[ADDR_W-1:SLOT_LSB]);
        ctrl_wen = ctrl_hit && wr;
        stat_wen = stat_hit && wr;
    end

endmodule

// File: rtl/sap_csr_ctrl.sv
// Control word register with plain, set and clear write paths.
// Holds its reset value while soft reset is set; locks the configuration
// fields while the engine is busy. Assumes one write per cycle at most.
module sap_csr_ctrl
    import sap_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wen,
    input  wr_op_e           op,
    input  logic [CSR_W-1:0] wdata,
    input  logic             busy,
    output logic [CSR_W-1:0] ctrl_q
);
    logic [CSR_W-1:0] merged;
    logic [CSR_W-1:0] ctrl_d;

    // Next control value: merge, apply busy lock, then soft reset override
    always_comb begin
        merged = ctrl_q;
        if (wen) begin
            merged = apply_op(ctrl_q, wdata, op) & CTRL_WMASK;
            if (busy) begin
                merged = (merged & ~LOCK_MASK) | (ctrl_q & LOCK_MASK);
            end
        end
        ctrl_d = merged[B_SRST] ? CTRL_RST : merged;
    end

    // Control register state
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/sap_csr_stat.sv
// Sticky FIFO error flags and the registered interrupt.
// A flag sets on its event pulse, clears only by the clear alias, and an
// event beats a clear in the same cycle. Soft reset zeroes all flags.
module sap_csr_stat #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             ien,
    input  logic             clr_en,
    input  logic [NFLAG-1:0] clr_bits,
    input  logic [NFLAG-1:0] ev,
    output logic [NFLAG-1:0] flags_q,
    output logic             irq_q
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic flag_d;

        // Next value of one sticky flag
        always_comb begin
            if (srst)                      flag_d = 1'b0;
            else if (ev[i])                flag_d = 1'b1;
            else if (clr_en && clr_bits[i]) flag_d = 1'b0;
            else                           flag_d = flags_q[i];
        end

        // Flag register
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[i] <= 1'b0;
            else        flags_q[i] <= flag_d;
        end
    end

    // Interrupt register from the enabled flags
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ien && (|flags_q);
    end

endmodule

// File: rtl/sap_csr_top.sv
// Control/status register block of a serial audio port.
// Decodes the register bus, holds the control word and the sticky error
// flags, and returns read data combinationally. Assumes single-cycle bus.
module sap_csr_top
    import sap_csr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [CSR_W-1:0]  bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_underflow,
    input  logic              eng_overflow,
    output logic [CSR_W-1:0]  ctl_o,
    output logic              irq_o
);
    logic             ctrl_hit, stat_hit, ctrl_wen, stat_wen;
    wr_op_e           op;
    logic [CSR_W-1:0] ctrl_q;
    logic [NUM_FLAGS-1:0] stat_flags;
    logic [CSR_W-1:0] stat_word;

    sap_csr_decode #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS),
        .STAT_OFS(STAT_OFS)
    ) u_dec (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .ctrl_hit(ctrl_hit),
        .stat_hit(stat_hit),
        .ctrl_wen(ctrl_wen),
        .stat_wen(stat_wen),
        .op      (op)
    );

    sap_csr_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (ctrl_wen),
        .op    (op),
        .wdata (bus_wdata),
        .busy  (eng_busy),
        .ctrl_q(ctrl_q)
    );

    sap_csr_stat #(
        .NFLAG(NUM_FLAGS)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (ctrl_q[B_SRST]),
        .ien     (ctrl_q[B_IEN]),
        .clr_en  (stat_wen && (op == OP_CLEAR)),
        .clr_bits(bus_wdata[S_FLAG_LSB +: NUM_FLAGS]),
        .ev      ({eng_overflow, eng_underflow}),
        .flags_q (stat_flags),
        .irq_q   (irq_o)
    );

    // Assemble the status word from the busy level and the flags
    always_comb begin
        stat_word = '0;
        stat_word[S_BUSY] = eng_busy;
        stat_word[S_FLAG_LSB +: NUM_FLAGS] = stat_flags;
    end

    // Read mux over the two register slots
    always_comb begin
        if (ctrl_hit)      bus_rdata = ctrl_q;
        else if (stat_hit) bus_rdata = stat_word;
        else               bus_rdata = '0;
    end

    assign ctl_o = ctrl_q;

endmodule

// File: rtl/sap_csr_chk.sv
// Assertion checker for sap_csr_top, attached with bind below.
// Assumes the default register offsets 0x00 and 0x10.
module sap_csr_chk
    import sap_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [CSR_W-1:0]     bus_wdata,
    input logic                 eng_busy,
    input logic                 eng_underflow,
    input logic                 eng_overflow,
    input logic [CSR_W-1:0]     ctl_o,
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 irq_o
);
    logic wr_now, clr_hit, unmapped;

    // Helper decodes of the bus
    always_comb begin
        wr_now   = bus_sel && bus_wr;
        clr_hit  = wr_now && (bus_addr == ADDR_W'('h18));
        unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr[3:2] == 2'b11) ||
                   (bus_addr >= ADDR_W'('h20));
    end

    a_r1_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && unmapped) |=> $stable(ctl_o));

    a_r3_srst_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[B_SRST] |-> (ctl_o == CTRL_RST));

    a_r5_busy_lock: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> (ctl_o[B_SRST] || ((ctl_o & LOCK_MASK) == ($past(ctl_o) & LOCK_MASK))));

    a_r6_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_underflow && !ctl_o[B_SRST]) |=> flags[0]);

    a_r6_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_overflow && !ctl_o[B_SRST]) |=> flags[1]);

    a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !ctl_o[B_SRST] && !(clr_hit && bus_wdata[S_FLAG_LSB])) |=> flags[0]);

    a_r8_srst_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[B_SRST] |=> (flags == '0));

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_o[B_IEN] || (flags == '0)) |=> !irq_o);

    a_r9_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[B_IEN] && (flags != '0)) |=> irq_o);

    // Busy may be anything; referenced so every input is used
    a_r5_busy_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(eng_busy));

endmodule

bind sap_csr_top sap_csr_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .eng_busy     (eng_busy),
    .eng_underflow(eng_underflow),
    .eng_overflow (eng_overflow),
    .ctl_o        (ctl_o),
    .flags        (stat_flags),
    .irq_o        (irq_o)
);

// File: tb/sap_csr_top_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// checked against a bench model written from the requirements.
module sap_csr_top_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_busy = 1'b0, eng_underflow = 1'b0, eng_overflow = 1'b0;
    logic [31:0] ctl_o;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_ctl;
    logic [1:0]  m_flags;
    logic        m_irq;

    always #(CLK_P/2) clk = ~clk;

    sap_csr_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_underflow(eng_underflow),
        .eng_overflow(eng_overflow), .ctl_o(ctl_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Mapped-alias test: returns slot (0 ctrl, 1 stat, -1 none)
    function automatic int slot_of(input logic [7:0] a);
        if (a[1:0] != 2'b00 || a[3:2] == 2'b11) return -1;
        if (a[7:4] == 4'h0) return 0;
        if (a[7:4] == 4'h1) return 1;
        return -1;
    endfunction

    function automatic logic [31:0] next_ctl(input logic [31:0] old, input logic wen,
                                             input logic [1:0] op, input logic [31:0] wd,
                                             input logic busy);
        logic [31:0] c;
        c = old;
        if (wen) begin
            if (op == 2'd0)      c = wd;
            else if (op == 2'd1) c = old | wd;
            else                 c = old & ~wd;
            c = c & 32'hC000_3FFF;
            if (busy) c = (c & ~32'h0000_3FF6) | (old & 32'h0000_3FF6);
        end
        if (c[31]) c = 32'hC000_0000;
        return c;
    endfunction

    function automatic logic [31:0] stat_exp(input logic busy);
        return {29'd0, m_flags, busy};
    endfunction

    // One clock: drive inputs, advance model, compare outputs after the edge
    task automatic step(input string req, input logic sel, input logic wr,
                        input logic [7:0] a, input logic [31:0] wd,
                        input logic busy, input logic uf, input logic ov);
        int          s;
        logic        wen;
        logic [31:0] nc;
        logic [1:0]  nf;
        logic        ni;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        eng_busy = busy; eng_underflow = uf; eng_overflow = ov;
        s   = slot_of(a);
        wen = sel && wr;
        nc  = next_ctl(m_ctl, wen && s == 0, a[3:2], wd, busy);
        for (int i = 0; i < 2; i++) begin
            if (m_ctl[31])                                    nf[i] = 1'b0;
            else if ((i == 0) ? uf : ov)                      nf[i] = 1'b1;
            else if (wen && s == 1 && a[3:2] == 2'd2 && wd[i+1]) nf[i] = 1'b0;
            else                                              nf[i] = m_flags[i];
        end
        ni = m_ctl[3] && (|m_flags);
        @(posedge clk);
        m_ctl = nc; m_flags = nf; m_irq = ni;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        eng_underflow = 1'b0; eng_overflow = 1'b0;
        check({req, " ctl_o"}, ctl_o, m_ctl);
        check({req, " irq_o"}, {31'd0, irq_o}, {31'd0, m_irq});
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input string req, input logic [7:0] a, input logic [31:0] wd,
                      input logic busy);
        step(req, 1'b1, 1'b1, a, wd, busy, 1'b0, 1'b0);
    endtask

    task automatic idle(input string req);
        step(req, 1'b0, 1'b0, 8'h00, 32'h0, eng_busy, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] addrs [11];
        int unsigned seed_val;
        seed_val = $urandom(32'd20240611);
        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h01, 8'h3C};

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        m_ctl = 32'hC000_0000; m_flags = 2'b00; m_irq = 1'b0;
        @(negedge clk);

        // R2 reset state
        check("R2 reset ctl_o", ctl_o, 32'hC000_0000);
        check("R2 reset irq", {31'd0, irq_o}, 32'd0);
        rd("R2 reset status", 8'h10, 32'h0);
        rd("R1 read ctrl at set alias", 8'h04, 32'hC000_0000);

        // R3 soft reset held blocks other fields
        wr("R3 write with srst kept", 8'h00, 32'h8000_00FF, 1'b0);
        check("R3 srst holds reset", ctl_o, 32'hC000_0000);
        // R8 events ignored in soft reset
        step("R8 event in srst", 1'b0, 1'b0, 8'h00, 0, 1'b0, 1'b1, 1'b1);
        rd("R8 flags stay zero", 8'h10, 32'h0);

        // R1 clear alias releases reset and gate
        wr("R1 clear alias", 8'h08, 32'hC000_0000, 1'b0);
        check("R1 clear alias result", ctl_o, 32'h0);
        wr("R1 set alias run", 8'h04, 32'h1, 1'b0);
        check("R1 set alias result", ctl_o, 32'h1);
        wr("R4 plain write", 8'h00, 32'h7FFF_FFFF, 1'b0);
        check("R4 reserved bits zero", ctl_o, 32'h4000_3FFF);
        wr("R1 clear gate", 8'h08, 32'h4000_0000, 1'b0);
        check("R1 clear gate result", ctl_o, 32'h0000_3FFF);

        // R1 unmapped writes ignored
        wr("R1 unmapped 0x0C", 8'h0C, 32'h0, 1'b0);
        wr("R1 unmapped 0x20", 8'h20, 32'h0, 1'b0);
        wr("R1 misaligned 0x01", 8'h01, 32'h0, 1'b0);
        check("R1 unmapped no change", ctl_o, 32'h0000_3FFF);
        rd("R1 unmapped reads zero", 8'h0C, 32'h0);

        // R5 busy lock
        wr("R5 write while busy", 8'h00, 32'h0, 1'b1);
        check("R5 locked fields kept", ctl_o, 32'h0000_3FF6);
        rd("R5 busy in status", 8'h10, 32'h1);
        wr("R5 write after busy", 8'h00, 32'h0000_0008, 1'b0);
        check("R5 unlocked write", ctl_o, 32'h0000_0008);

        // R6 event sets flag; R9 irq lags by one edge
        step("R6 underflow event", 1'b0, 1'b0, 8'h00, 0, 1'b0, 1'b1, 1'b0);
        rd("R6 underflow flag", 8'h10, 32'h2);
        check("R9 irq not yet", {31'd0, irq_o}, 32'd0);
        idle("R9 idle");
        check("R9 irq raised", {31'd0, irq_o}, 32'd1);

        // R7 plain and set writes to status ignored
        wr("R7 plain status", 8'h10, 32'h0, 1'b0);
        wr("R7 set status", 8'h14, 32'h4, 1'b0);
        rd("R7 status unchanged", 8'h10, 32'h2);

        // R6 event beats clear in same cycle
        step("R6 clear with event", 1'b1, 1'b1, 8'h18, 32'h2, 1'b0, 1'b1, 1'b0);
        rd("R6 event wins", 8'h10, 32'h2);
        wr("R6 clear alone", 8'h18, 32'h2, 1'b0);
        rd("R6 flag cleared", 8'h10, 32'h0);
        step("R6 overflow event", 1'b0, 1'b0, 8'h00, 0, 1'b0, 1'b0, 1'b1);
        rd("R6 overflow flag", 8'h10, 32'h4);
        idle("R9 idle2");
        wr("R9 disable irq", 8'h08, 32'h8, 1'b0);
        idle("R9 idle3");
        check("R9 irq gated off", {31'd0, irq_o}, 32'd0);

        // R3 and R8 soft reset via set alias
        wr("R3 srst via set", 8'h04, 32'h8000_0000, 1'b0);
        check("R3 srst result", ctl_o, 32'hC000_0000);
        idle("R8 idle");
        rd("R8 flags cleared", 8'h10, 32'h0);

        // Random traffic against the model
        for (int it = 0; it < 600; it++) begin
            logic [7:0]  a;
            logic [31:0] wd;
            logic        b, uf, ov;
            a  = addrs[$urandom % 11];
            wd = $urandom;
            if ($urandom % 4 != 0) wd[31] = 1'b0;
            if ($urandom % 2 == 0) wd[30] = 1'b0;
            b  = ($urandom % 3 == 0);
            uf = ($urandom % 6 == 0);
            ov = ($urandom % 7 == 0);
            step("R1 R4 R5 R6 random", ($urandom % 4 != 0), ($urandom % 3 != 0),
                 a, wd, b, uf, ov);
            rd("R6 R8 random status", 8'h10, stat_exp(b));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule